// File: doc/BRIEF.md
# Multi-Ratio Output Clock Divider

This block produces one configurable clock output. It picks one of two source clocks, divides it by a ratio taken from a fixed list of eighteen values, and drives the result to an output pad. The pad can be disabled by an output-enable line. The list holds odd and irregular divisors such as 3, 5 and 13 as well as the even ones. For every ratio of two or more, the output high phase is exactly half the output period, at a resolution of half a source period.

Several copies of the block can sit on the same source clock and the same reset. Their counters leave reset on the same source edge, so outputs at the same or related ratios keep their rising edges aligned. A ratio can be changed while the clock runs. The new value is loaded only when the current count finishes, so the output never shows a pulse narrower than one source period. The source selection is static configuration and is changed only while reset is held.

Top module: `clkout_divider`

## Requirements
- R1: `ratio_sel` values 0 to 17 select the divisors 1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96 and 104, in that order. Values 18 to 31 select 104. For a divisor N, the output period is N times the period of the selected source.
- R2: `src_sel` = 0 divides `src_clk[0]` and `src_sel` = 1 divides `src_clk[1]`. It is changed only while `rst_n` is low.
- R3: For every divisor of 2 or more, the high phase is exactly half the output period. For odd N this is N/2 source periods, made up of whole periods plus one half period.
- R4: A divisor of 1 passes the selected source clock to the output unchanged, so its high phase is half a source period.
- R5: A new `ratio_sel` takes effect on the source rising edge that ends the count in progress. The next output period starts on that edge. If the old divisor is odd, its last low phase is therefore half a source period shorter than usual. No high or low phase is ever shorter than one source period when both divisors are 2 or more.
- R6: While `rst_n` is low, the output is low. Counting resumes two source rising edges after release. Instances on the same source and reset produce identical outputs at equal ratios. At divisors 4 and 8, every rising edge of the divide-by-8 output coincides with a rising edge of the divide-by-4 output.
- R7: While `oe` is low, `clk_pad_oe` is low and `clk_pad_o` is held low. The counter keeps running, so when `oe` returns high the output is in the same phase as an instance that was never disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 2 | Two candidate source clocks |
| src_sel | input | 1 | Source choice, static outside reset |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| ratio_sel | input | SEL_W | Index into the divisor list |
| oe | input | 1 | Output enable for the pad |
| clk_pad_o | output | 1 | Divided clock toward the pad |
| clk_pad_oe | output | 1 | Pad driver enable; low means high impedance |

## Verification
Some internal faults would change the output. A count that wraps at the wrong value or a wrong table entry shows as a wrong output period within a single output cycle. A half-cycle copy that is missing or wrongly combined shows as a high phase that is not half the period, again within one cycle. Loading the ratio at the wrong moment shows as a truncated phase in the period where the change happens. A reset release that is not aligned shows as a fixed offset between two instances, visible at their first rising edges. When the output is gated, a counter that stalls shows as a phase mismatch with a never-disabled peer as soon as the enable returns.

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider #(
  parameter int SEL_W = 5,
  parameter int CNT_W = 7
) (
  input  logic [1:0]       src_clk,
  input  logic             src_sel,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             oe,
  output logic             clk_pad_o,
  output logic             clk_pad_oe
);

  function automatic logic [CNT_W-1:0] ratio_of(input logic [SEL_W-1:0] idx);
    case (idx)
      SEL_W'(0):  return CNT_W'(1);
      SEL_W'(1):  return CNT_W'(2);
      SEL_W'(2):  return CNT_W'(3);
      SEL_W'(3):  return CNT_W'(4);
      SEL_W'(4):  return CNT_W'(5);
      SEL_W'(5):  return CNT_W'(6);
      SEL_W'(6):  return CNT_W'(8);
      SEL_W'(7):  return CNT_W'(10);
      SEL_W'(8):  return CNT_W'(12);
      SEL_W'(9):  return CNT_W'(13);
      SEL_W'(10): return CNT_W'(20);
      SEL_W'(11): return CNT_W'(24);
      SEL_W'(12): return CNT_W'(26);
      SEL_W'(13): return CNT_W'(40);
      SEL_W'(14): return CNT_W'(48);
      SEL_W'(15): return CNT_W'(52);
      SEL_W'(16): return CNT_W'(96);
      default:    return CNT_W'(104);
    endcase
  endfunction

  logic             clk_sel;
  logic [1:0]       rel_sync;
  logic             run;
  logic [CNT_W-1:0] cnt, div_n, nxt_cnt, nxt_n, req_n;
  logic             last, q_r, q_f, div_clk;

  assign clk_sel = src_sel ? src_clk[1] : src_clk[0];
  assign run     = rel_sync[1];
  assign req_n   = ratio_of(ratio_sel);
  assign last    = (cnt == div_n - 1'b1);
  assign nxt_cnt = last ? '0 : cnt + 1'b1;
  assign nxt_n   = last ? req_n : div_n;

  always_ff @(posedge clk_sel or negedge rst_n)
    if (!rst_n) rel_sync <= '0;
    else        rel_sync <= {rel_sync[0], 1'b1};

  always_ff @(posedge clk_sel or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      div_n <= CNT_W'(1);
      q_r   <= 1'b0;
    end else if (!run) begin
      cnt   <= req_n - 1'b1;
      div_n <= req_n;
      q_r   <= 1'b0;
    end else begin
      cnt   <= nxt_cnt;
      div_n <= nxt_n;
      q_r   <= nxt_cnt < ((nxt_n + 1'b1) >> 1);
    end

  always_ff @(negedge clk_sel or negedge rst_n)
    if (!rst_n) q_f <= 1'b0;
    else        q_f <= q_r;

  assign div_clk    = (div_n == CNT_W'(1)) ? (clk_sel & run)
                    : (div_n[0] ? (q_r & q_f) : q_r);
  assign clk_pad_o  = oe & div_clk;
  assign clk_pad_oe = oe;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_sel) disable iff (!rst_n)
    cnt < div_n);  // R1
  AST_CNT_WRAP: assert property (@(posedge clk_sel) disable iff (!rst_n)
    run && last |=> cnt == '0);  // R1
  AST_RATIO_AT_END: assert property (@(posedge clk_sel) disable iff (!rst_n)
    run && !last |=> div_n == $past(div_n));  // R5
  AST_HALF_CYCLE_COPY: assert property (@(posedge clk_sel) disable iff (!rst_n)
    q_f == q_r);  // R3
  AST_HELD_IN_RESET: assert property (@(negedge clk_sel) disable iff (!rst_n)
    !run |-> !clk_pad_o);  // R6

endmodule

// File: tb/test_clkout_divider.sv
`timescale 1ns/1ps
module test_clkout_divider;
  localparam int CLK_PERIOD = 10;
  localparam int ALT_PERIOD = 14;
  localparam int WATCHDOG   = 150000 * CLK_PERIOD;

  logic s0 = 1'b0, s1 = 1'b0;
  logic [1:0] src_clk;
  logic rst_n = 1'b0, src_sel = 1'b0, m_oe = 1'b1;
  logic [4:0] m_ratio = 5'd3, p_ratio = 5'd3;
  logic m_pad, m_pad_oe, p_pad, p_pad_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign src_clk = {s1, s0};
  initial forever #(CLK_PERIOD/2) s0 = ~s0;
  initial forever #(ALT_PERIOD/2) s1 = ~s1;

  clkout_divider i_clkout_divider (.src_clk(src_clk), .src_sel(src_sel), .rst_n(rst_n),
    .ratio_sel(m_ratio), .oe(m_oe), .clk_pad_o(m_pad), .clk_pad_oe(m_pad_oe));
  clkout_divider i_peer (.src_clk(src_clk), .src_sel(src_sel), .rst_n(rst_n),
    .ratio_sel(p_ratio), .oe(1'b1), .clk_pad_o(p_pad), .clk_pad_oe(p_pad_oe));

  function automatic int exp_ratio(input int idx);
    int tbl[18] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96, 104};
    return (idx < 18) ? tbl[idx] : 104;
  endfunction

  function automatic int src_period(input bit sel);
    return sel ? ALT_PERIOD : CLK_PERIOD;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int per, output int hi);
    time t0, t1, t2;
    @(posedge m_pad); t0 = $time;
    @(negedge m_pad); t1 = $time;
    @(posedge m_pad); t2 = $time;
    per = int'(t2 - t0);
    hi  = int'(t1 - t0);
  endtask

  task automatic do_reset(input bit sel, input logic [4:0] mr, input logic [4:0] pr);
    rst_n = 1'b0;
    #3;
    src_sel = sel; m_ratio = mr; p_ratio = pr;
    #(ALT_PERIOD * 3);
    check(m_pad == 1'b0 && p_pad == 1'b0, "R6 output low in reset", int'(m_pad), 0);
    rst_n = 1'b1;
  endtask

  time t_mrise = 0;
  bit align_on = 0;
  int p_rises = 0, mis = 0;
  always @(posedge m_pad) t_mrise = $time;
  always @(posedge p_pad) if (align_on) begin
    #1;
    p_rises++;
    if (t_mrise != $time - 1) mis++;
  end

  bit mon_on = 0;
  time last_edge = 0;
  int min_phase = 1000000;
  always @(posedge m_pad or negedge m_pad) begin
    if (mon_on && int'($time - last_edge) < min_phase) min_phase = int'($time - last_edge);
    last_edge = $time;
  end

  initial begin
    #(WATCHDOG);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int per, hi, diff;
    time t0;
    void'($urandom(32'd2024));

    // R1 R3 R6: divide by 4 and 8 with aligned edges
    do_reset(1'b0, 5'd3, 5'd6);
    measure(per, hi);
    check(per == 40, "R1 period div4", per, 40);
    check(hi == 20, "R3 high div4", hi, 20);
    p_rises = 0; mis = 0; align_on = 1;
    #(CLK_PERIOD * 60);
    align_on = 0;
    check(p_rises > 0 && mis == 0, "R6 div8 rises on div4 rises", mis, 0);

    // R3 R6: odd ratio 13, two instances identical
    do_reset(1'b0, 5'd9, 5'd9);
    measure(per, hi);
    check(per == 130, "R1 period div13", per, 130);
    check(hi == 65, "R3 high div13", hi, 65);
    diff = 0;
    for (int k = 0; k < 100; k++) begin
      #3;
      if (m_pad != p_pad) diff++;
    end
    check(diff == 0, "R6 same-ratio outputs identical", diff, 0);

    // R4: divide by one
    do_reset(1'b0, 5'd0, 5'd0);
    measure(per, hi);
    check(per == CLK_PERIOD && hi == CLK_PERIOD/2, "R4 pass-through", per, CLK_PERIOD);

    // R2: alternate source, ratio 3
    do_reset(1'b1, 5'd2, 5'd2);
    measure(per, hi);
    check(per == 3 * ALT_PERIOD, "R2 alt source period", per, 3 * ALT_PERIOD);
    check(hi == 3 * ALT_PERIOD / 2, "R3 high div3 alt", hi, 3 * ALT_PERIOD / 2);

    // R1: index above the list decodes as 104
    do_reset(1'b0, 5'd25, 5'd25);
    measure(per, hi);
    check(per == 1040, "R1 out-of-list index", per, 1040);

    // R5: change from 3 to 8 mid-period
    do_reset(1'b0, 5'd2, 5'd2);
    measure(per, hi);
    t0 = $time;
    min_phase = 1000000; mon_on = 1;
    #1; m_ratio = 5'd6;
    @(posedge m_pad);
    check(int'($time - t0) == 25, "R5 old period completes", int'($time - t0), 25);
    measure(per, hi);
    mon_on = 0;
    check(per == 80, "R5 new ratio period", per, 80);
    check(min_phase >= CLK_PERIOD, "R5 no runt phase", min_phase, CLK_PERIOD);

    // R7: output enable
    do_reset(1'b0, 5'd3, 5'd3);
    measure(per, hi);
    #2; m_oe = 1'b0;
    diff = 0;
    for (int k = 0; k < 60; k++) begin
      #3;
      if (m_pad !== 1'b0 || m_pad_oe !== 1'b0) diff++;
    end
    check(diff == 0, "R7 disabled pad quiet", diff, 0);
    m_oe = 1'b1;
    diff = 0;
    for (int k = 0; k < 60; k++) begin
      #3;
      if (m_pad != p_pad || m_pad_oe !== 1'b1) diff++;
    end
    check(diff == 0, "R7 phase kept after enable", diff, 0);

    // R1 R2 R3: random configurations
    for (int it = 0; it < 12; it++) begin
      int idx, n, tp;
      bit sel;
      idx = int'($urandom % 32);
      sel = bit'($urandom % 2);
      n = exp_ratio(idx);
      tp = src_period(sel);
      do_reset(sel, 5'(idx), 5'(idx));
      measure(per, hi);
      check(per == n * tp, "R1 R2 random period", per, n * tp);
      check(2 * hi == per, "R3 random half high", 2 * hi, per);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule